// File: doc/BRIEF.md
# Selectable Half-Band Decimation Cascade

This block lowers the sample rate of a complex baseband stream, carried as separate I and Q words, by 2, 4, 8 or 16. It does this with a cascade of identical half-band decimate-by-2 filters. The stage nearest the output is always in use. A 2-bit selection adds one, two or three further stages in front of it. Samples enter at the stage with the highest enabled index, which runs at the full input rate. Each later stage runs at half the rate of the one before it. The mandatory stage is the last filter ahead of the output.

Each stage uses an 11-tap symmetric kernel in which every tap an even distance from the centre is zero. Because of that, a stage needs only four distinct coefficients. Output words are rounded and clamped to the input width.

The selection is meant to be held steady while samples flow. Change it only together with a reset.

Top module: `hb_decim_chain`

## Requirements
- R1: While `rst` is high and on the cycle after it, `out_valid` is 0 and both `out_i` and `out_q` read 0.
- R2: With selection `sel` = N (0..3), stages 0 through N are active. Exactly one output is produced for every 2^(N+1) accepted input samples, and two outputs are never on consecutive cycles.
- R3: Each stage forms 32·x[n-5] + 20·(x[n-4]+x[n-6]) − 5·(x[n-2]+x[n-8]) + (x[n]+x[n-10]) + 32, then shifts the sum arithmetically right by 6. The taps at distances 2 and 4 from the centre are zero. The history is all zero after reset.
- R4: A stage result above 2^(W-1)−1 is clamped to 2^(W-1)−1, and a result below −2^(W-1) is clamped to −2^(W-1).
- R5: `out_valid` is high exactly N+1 cycles after the input sample that completes a group of 2^(N+1) samples was accepted.
- R6: Cycles with `in_valid` low are ignored. Gaps in the input stream do not change any output value.
- R7: I and Q are filtered independently with the same kernel. Neither channel's output depends on the other's input.
- R8: Between valid strobes, `out_i` and `out_q` hold the last emitted values.
- R9: Each stage emits on the second, fourth, sixth, … sample it receives after reset. The window always includes the newest sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 2 | Number of optional stages in use (0..3) |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Input in-phase word, two's complement |
| in_q | input | 16 | Input quadrature word, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Decimated in-phase word |
| out_q | output | 16 | Decimated quadrature word |

## Verification
Every stage registers its result once, so an output is due N+1 clock edges after the input that completes its group. Earlier inputs in the group have no bearing on that timing.

When the driver hands a sample to the bench model, it also records the current cycle. Whenever the model yields an output, the driver queues that output with the recorded cycle plus N+1. The monitor pops an item on each strobe and compares the cycle counter against that due value as well as the data. The monitor samples on the falling edge, half a period after the register updates, so the counter and the outputs are both settled.

// File: rtl/hb_decim_chain.sv
module hb_decim_chain #(
  parameter int DW  = 16,
  parameter int NST = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [$clog2(NST)-1:0] sel,
  input  logic                  in_valid,
  input  logic signed [DW-1:0]  in_i,
  input  logic signed [DW-1:0]  in_q,
  output logic                  out_valid,
  output logic signed [DW-1:0]  out_i,
  output logic signed [DW-1:0]  out_q
);
  localparam int SW   = $clog2(NST);
  localparam int TAPS = 11;
  localparam int AW   = DW + 8;
  localparam int SH   = 6;
  localparam logic signed [AW-1:0] CC   = 32;
  localparam logic signed [AW-1:0] C1   = 20;
  localparam logic signed [AW-1:0] C3   = -5;
  localparam logic signed [AW-1:0] C5   = 1;
  localparam logic signed [AW-1:0] RND  = 32;
  localparam logic signed [AW-1:0] SMAX = (AW'(1) <<< (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] SMIN = -SMAX - AW'(1);

  function automatic logic signed [DW-1:0] kern(
    input logic signed [DW-1:0] t0, t2, t4, t5, t6, t8, t10);
    logic signed [AW-1:0] acc;
    acc = CC * AW'(t5) + C1 * (AW'(t4) + AW'(t6)) + C3 * (AW'(t2) + AW'(t8))
        + C5 * (AW'(t0) + AW'(t10)) + RND;
    acc = acc >>> SH;
    if (acc > SMAX) acc = SMAX;
    else if (acc < SMIN) acc = SMIN;
    return acc[DW-1:0];
  endfunction

  logic                 vin [NST];
  logic signed [DW-1:0] xi  [NST];
  logic signed [DW-1:0] xq  [NST];
  logic                 vo  [NST];
  logic signed [DW-1:0] io  [NST];
  logic signed [DW-1:0] qo  [NST];

  for (genvar k = 0; k < NST; k++) begin : g_st
    if (k == NST - 1) begin : g_head
      assign vin[k] = (sel == SW'(k)) && in_valid;
      assign xi[k]  = in_i;
      assign xq[k]  = in_q;
    end else begin : g_link
      assign vin[k] = (sel == SW'(k)) ? in_valid : ((sel > SW'(k)) && vo[k+1]);
      assign xi[k]  = (sel == SW'(k)) ? in_i : io[k+1];
      assign xq[k]  = (sel == SW'(k)) ? in_q : qo[k+1];
    end

    logic signed [DW-1:0] wi [TAPS-1];
    logic signed [DW-1:0] wq [TAPS-1];
    logic                 ph, r_v;
    logic signed [DW-1:0] r_i, r_q, fi, fq;

    assign fi = kern(xi[k], wi[1], wi[3], wi[4], wi[5], wi[7], wi[9]);
    assign fq = kern(xq[k], wq[1], wq[3], wq[4], wq[5], wq[7], wq[9]);

    always_ff @(posedge clk) begin
      if (rst) begin
        ph  <= 1'b0;
        r_v <= 1'b0;
        r_i <= '0;
        r_q <= '0;
        for (int j = 0; j < TAPS - 1; j++) begin
          wi[j] <= '0;
          wq[j] <= '0;
        end
      end else begin
        r_v <= vin[k] && ph;
        if (vin[k]) begin
          ph    <= !ph;
          wi[0] <= xi[k];
          wq[0] <= xq[k];
          for (int j = 1; j < TAPS - 1; j++) begin
            wi[j] <= wi[j-1];
            wq[j] <= wq[j-1];
          end
          if (ph) begin
            r_i <= fi;
            r_q <= fq;
          end
        end
      end
    end

    assign vo[k] = r_v;
    assign io[k] = r_i;
    assign qo[k] = r_q;
  end

  assign out_valid = vo[0];
  assign out_i     = io[0];
  assign out_q     = qo[0];

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_i == '0 && out_q == '0));

  // R2
  spaced_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(vin[0]));

  // R6
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == '0 && !in_valid) |=> !out_valid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vin[0] |=> ($stable(out_i) && $stable(out_q)));
endmodule

// File: tb/hb_decim_chain_test.sv
module hb_decim_chain_test;
  localparam int DW  = 16;
  localparam int NST = 4;
  localparam int MAXV = 32767;
  localparam int MINV = -32768;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] sel = 2'd0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic signed [DW-1:0] out_i, out_q;

  hb_decim_chain #(.DW(DW), .NST(NST)) uut (
    .clk(clk), .rst(rst), .sel(sel), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, n_out = 0;
  bit done = 1'b0, sat_hi = 1'b0, sat_lo = 1'b0;
  int exp_i[$], exp_q[$], exp_due[$], log_i[$], log_q[$];
  int mi[NST][10], mq[NST][10];
  bit mph[NST];
  int last_i = 0, last_q = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int kern_m(int t0, int t2, int t4, int t5, int t6, int t8, int t10);
    int a;
    a = 32 * t5 + 20 * (t4 + t6) - 5 * (t2 + t8) + t0 + t10 + 32;
    a = a >>> 6;
    if (a > MAXV) a = MAXV;
    if (a < MINV) a = MINV;
    return a;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NST; k++) begin
      mph[k] = 1'b0;
      for (int j = 0; j < 10; j++) begin
        mi[k][j] = 0;
        mq[k][j] = 0;
      end
    end
  endtask

  task automatic model_step(int xi, int xq);
    int vi = xi, vq = xq, yi, yq, s;
    bit go = 1'b1;
    s = int'(sel);
    for (int k = s; k >= 0; k--) begin
      if (go) begin
        yi = kern_m(vi, mi[k][1], mi[k][3], mi[k][4], mi[k][5], mi[k][7], mi[k][9]);
        yq = kern_m(vq, mq[k][1], mq[k][3], mq[k][4], mq[k][5], mq[k][7], mq[k][9]);
        for (int j = 9; j > 0; j--) begin
          mi[k][j] = mi[k][j-1];
          mq[k][j] = mq[k][j-1];
        end
        mi[k][0] = vi;
        mq[k][0] = vq;
        if (mph[k]) begin
          vi = yi;
          vq = yq;
        end else go = 1'b0;
        mph[k] = !mph[k];
      end
    end
    if (go) begin
      exp_i.push_back(vi);
      exp_q.push_back(vq);
      exp_due.push_back(cyc + s + 1);
    end
  endtask

  task automatic drive(int a, int b);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = DW'(a);
    in_q = DW'(b);
    model_step(a, b);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic do_reset(int s);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    sel = 2'(s);
    model_reset();
    exp_i.delete(); exp_q.delete(); exp_due.delete();
    log_i.delete(); log_q.delete();
    n_out = 0; last_i = 0; last_q = 0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(out_i == 0 && out_q == 0, "R1", "outputs in reset", int'(out_i), 0);
    rst = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        n_out++;
        log_i.push_back(int'(out_i));
        log_q.push_back(int'(out_q));
        if (int'(out_i) == MAXV) sat_hi = 1'b1;
        if (int'(out_q) == MINV) sat_lo = 1'b1;
        if (exp_i.size() == 0) begin
          check(1'b0, "R2", "unexpected output", int'(out_i), 0);
        end else begin
          int ei, eq, ed;
          ei = exp_i.pop_front();
          eq = exp_q.pop_front();
          ed = exp_due.pop_front();
          check(int'(out_i) == ei, "R3", "I value", int'(out_i), ei);
          check(int'(out_q) == eq, "R7", "Q value", int'(out_q), eq);
          check(cyc == ed, "R5", "output cycle", cyc, ed);
        end
        last_i = int'(out_i);
        last_q = int'(out_q);
      end else begin
        check(int'(out_i) == last_i && int'(out_q) == last_q, "R8", "hold I",
              int'(out_i), last_i);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R3 / R9: impulse in the second sample, one stage
    do_reset(0);
    drive(0, 0);
    drive(640, -640);
    for (int k = 0; k < 10; k++) drive(0, 0);
    idle(6);
    begin
      int ref_v[6] = '{10, -50, 200, 200, -50, 10};
      check(log_i.size() == 6, "R9", "impulse output count", log_i.size(), 6);
      for (int k = 0; k < 6 && k < log_i.size(); k++) begin
        check(log_i[k] == ref_v[k], "R3", "impulse tap I", log_i[k], ref_v[k]);
        check(log_q[k] == -ref_v[k], "R7", "impulse tap Q", log_q[k], -ref_v[k]);
      end
    end

    // R2 / R6: random data with gaps for every selection
    for (int s = 0; s < NST; s++) begin
      int n_in;
      do_reset(s);
      n_in = 12 << (s + 1);
      for (int k = 0; k < n_in; k++) begin
        drive($urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768);
        if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
      end
      idle(12);
      check(n_out == 12, "R2", "output count", n_out, 12);
      check(exp_i.size() == 0, "R2", "missing outputs", exp_i.size(), 0);
    end

    // R4: clamp high on I, clamp low on Q
    do_reset(0);
    for (int k = 0; k < 24; k++) begin
      if (k % 6 == 5) drive(MINV, MAXV);
      else drive(MAXV, MINV);
    end
    idle(4);
    check(sat_hi, "R4", "I clamped to max", int'(sat_hi), 1);
    check(sat_lo, "R4", "Q clamped to min", int'(sat_lo), 1);
    check(exp_i.size() == 0, "R4", "missing outputs", exp_i.size(), 0);

    // R4 / R2: same pattern through the full cascade
    do_reset(3);
    for (int k = 0; k < 64; k++) begin
      if (k % 6 == 5) drive(MINV, MAXV);
      else drive(MAXV, MINV);
    end
    idle(8);
    check(n_out == 4, "R2", "full cascade count", n_out, 4);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule